// File: doc/BRIEF.md
# Registered Sum-of-Products Logic Array

A configurable AND-OR array, shaped like a small programmable logic device with some outputs registered. Eight dedicated logic inputs and the four flip-flop values together form a twelve-signal array bus. Each product term can take the true copy, the inverted copy, or neither copy of each bus signal. Every output ORs its own eight terms. Four outputs are latched into D flip-flops on the rising edge of the dedicated clock. The other four leave the array directly.

The configuration is a static vector on `cfg_i`. It is held while the block runs, or it is loaded while reset is active. The registered pins are driven only while the dedicated enable is high. A mirror of that enable is given out so that the tri-state pin can be checked without resolving high impedance. The signal fed back into the array is always taken from the flip-flop and never from the pin. Because of this, a registered state machine keeps advancing while its pins float.

Top module: `pal_array`

## Requirements
- R1: Product term p of output o occupies the 25 bits of `cfg_i` that start at bit (o*8+p)*25. Array signal k (0..7 = `in_i[k]`, 8..11 = flip-flop k-8) has two bits in this field: bit 2k selects the true copy and bit 2k+1 selects the complement. A term is the AND of all the copies it selects.
- R2: A term that selects both the true copy and the complement of any one signal evaluates to 0.
- R3: Bit 24 of a term field enables the term. A disabled term adds nothing to the OR. An enabled term that selects no copies evaluates to 1. An output with no enabled term is 0.
- R4: Each output is the OR of its eight product terms.
- R5: Outputs 4..7 appear on `comb_o[0..3]` without a clock. They follow `in_i` within the same cycle.
- R6: Outputs 0..3 are captured into flip-flops on each rising edge of `clk_i`.
- R7: The flip-flop values, not the pins, are array signals 8..11. This holds whatever the state of the enable.
- R8: While `reg_oe_i` is low, `reg_q_o` is high impedance and `reg_oe_o` is low. While it is high, `reg_q_o` shows the flip-flops and `reg_oe_o` is high.
- R9: A low `rst_ni` clears all four flip-flops at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dedicated clock for the registered outputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 1600 | Static array configuration |
| in_i | input | 8 | Dedicated logic inputs |
| reg_oe_i | input | 1 | Output enable for the registered pins |
| reg_q_o | output | 4 | Registered outputs, tri-stated when disabled |
| reg_oe_o | output | 1 | Registered-output enable flag |
| comb_o | output | 4 | Combinational outputs |

## Verification
A flip-flop capture and a change of output enable can happen on the same edge. The bench lowers `reg_oe_i` while a three-bit counter, built from feedback terms, keeps stepping. It checks the enable flag throughout the floating window. When the pins return, the count must equal the total number of edges since reset, which shows that the feedback came from the flip-flops. Combinational evaluation and register capture are also checked together under random configurations. For each input pattern, the combinational outputs are compared before the edge and the registered outputs after it, using a bench model of the term encoding.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    LIT_IGNORE = 2'b00,
    LIT_TRUE   = 2'b01,
    LIT_COMP   = 2'b10,
    LIT_BOTH   = 2'b11
  } lit_e;

  function automatic int term_base(int o, int p, int n_pt, int term_w);
    return (o * n_pt + p) * term_w;
  endfunction
endpackage

// File: rtl/pal_term.sv
module pal_term #(
  parameter int N_ARR = 12,
  localparam int TERM_W = 2 * N_ARR + 1
) (
  input  logic [N_ARR-1:0]  arr_i,
  input  logic [TERM_W-1:0] cfg_i,
  output logic              term_o
);
  import pal_pkg::*;

  always_comb begin
    term_o = cfg_i[TERM_W-1];
    for (int k = 0; k < N_ARR; k++) begin
      unique case (lit_e'(cfg_i[2*k +: 2]))
        LIT_TRUE:   term_o = term_o & arr_i[k];
        LIT_COMP:   term_o = term_o & ~arr_i[k];
        LIT_BOTH:   term_o = 1'b0;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pal_sop.sv
module pal_sop #(
  parameter int N_ARR = 12,
  parameter int N_PT  = 8,
  localparam int TERM_W = 2 * N_ARR + 1
) (
  input  logic [N_ARR-1:0]       arr_i,
  input  logic [N_PT*TERM_W-1:0] cfg_i,
  output logic                   sum_o
);
  logic [N_PT-1:0] term_w;

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    pal_term #(.N_ARR(N_ARR)) u_term (
      .arr_i (arr_i),
      .cfg_i (cfg_i[p*TERM_W +: TERM_W]),
      .term_o(term_w[p])
    );
  end

  assign sum_o = |term_w;
endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN   = 8,
  parameter int N_REG  = 4,
  parameter int N_COMB = 4,
  parameter int N_PT   = 8,
  localparam int N_ARR  = N_IN + N_REG,
  localparam int N_OUT  = N_REG + N_COMB,
  localparam int TERM_W = 2 * N_ARR + 1,
  localparam int OUT_W  = N_PT * TERM_W,
  localparam int CFG_W  = N_OUT * OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic              reg_oe_i,
  output logic [N_REG-1:0]  reg_q_o,
  output logic              reg_oe_o,
  output logic [N_COMB-1:0] comb_o
);
  logic [N_REG-1:0] reg_q;
  logic [N_ARR-1:0] arr_w;
  logic [N_OUT-1:0] sum_w;

  // feedback taken from flops, never from pins
  assign arr_w = {reg_q, in_i};

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pal_sop #(.N_ARR(N_ARR), .N_PT(N_PT)) u_sop (
      .arr_i(arr_w),
      .cfg_i(cfg_i[o*OUT_W +: OUT_W]),
      .sum_o(sum_w[o])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= sum_w[N_REG-1:0];
  end

  assign comb_o   = sum_w[N_OUT-1:N_REG];
  assign reg_q_o  = reg_oe_i ? reg_q : 'z;
  assign reg_oe_o = reg_oe_i;
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int N_IN   = 8,
  parameter int N_REG  = 4,
  parameter int N_COMB = 4,
  parameter int N_PT   = 8,
  localparam int N_ARR  = N_IN + N_REG,
  localparam int TERM_W = 2 * N_ARR + 1,
  localparam int CFG_W  = (N_REG + N_COMB) * N_PT * TERM_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CFG_W-1:0]  cfg_i,
  input logic [N_IN-1:0]   in_i,
  input logic              reg_oe_i,
  input logic [N_REG-1:0]  reg_q_o,
  input logic [N_COMB-1:0] comb_o,
  input logic [N_REG-1:0]  reg_q,
  input logic [N_REG-1:0]  reg_d
);
  import pal_pkg::*;

  logic [N_COMB-1:0] any_en;
  always_comb begin
    any_en = '0;
    for (int j = 0; j < N_COMB; j++)
      for (int p = 0; p < N_PT; p++)
        any_en[j] = any_en[j] | cfg_i[term_base(N_REG + j, p, N_PT, TERM_W) + TERM_W - 1];
  end

  // R6
  reg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> reg_q == $past(reg_d));

  // R8
  pin_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_oe_i |-> reg_q_o == reg_q);

  // R5
  comb_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(in_i) && $stable(reg_q) && $stable(cfg_i)) |-> $stable(comb_o));

  // R3
  no_term_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_o & ~any_en) == '0);

  // R9
  always_ff @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (reg_q == '0);
  end
endmodule

bind pal_array pal_array_chk #(
  .N_IN(N_IN), .N_REG(N_REG), .N_COMB(N_COMB), .N_PT(N_PT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .in_i(in_i),
  .reg_oe_i(reg_oe_i), .reg_q_o(reg_q_o), .comb_o(comb_o),
  .reg_q(reg_q), .reg_d(sum_w[N_REG-1:0])
);

// File: tb/pal_array_test.sv
module pal_array_test;
  localparam int TW = 25;
  localparam int CW = 8 * 8 * TW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [CW-1:0] cfg_i = '0;
  logic [7:0]    in_i = '0;
  logic          reg_oe_i = 1'b1;
  logic [3:0]    reg_q_o;
  logic          reg_oe_o;
  logic [3:0]    comb_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  logic exp_r3 = 1'b0;

  always #2 clk_i = ~clk_i;

  pal_array uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .in_i(in_i),
    .reg_oe_i(reg_oe_i), .reg_q_o(reg_q_o), .reg_oe_o(reg_oe_o), .comb_o(comb_o)
  );

  // edge-counting reference for the directed counter program
  always @(posedge clk_i) begin
    if (rst_ni) begin
      exp_cnt <= exp_cnt + 1;
      exp_r3  <= in_i[3];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lit(input int o, input int p, input int k, input bit t, input bit c);
    cfg_i[(o*8+p)*TW + 2*k]     = t;
    cfg_i[(o*8+p)*TW + 2*k + 1] = c;
  endtask

  task automatic ten(input int o, input int p);
    cfg_i[(o*8+p)*TW + 24] = 1'b1;
  endtask

  function automatic bit model(input int o, input logic [7:0] v, input logic [3:0] q);
    logic [11:0] a;
    bit s;
    a = {q, v};
    s = 1'b0;
    for (int p = 0; p < 8; p++) begin
      int b;
      bit t;
      b = (o*8+p)*TW;
      if (cfg_i[b+24]) begin
        t = 1'b1;
        for (int k = 0; k < 12; k++) begin
          if (cfg_i[b+2*k]   && !a[k]) t = 1'b0;
          if (cfg_i[b+2*k+1] &&  a[k]) t = 1'b0;
        end
        s = s | t;
      end
    end
    return s;
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] q;
    logic [3:0] nxt;
    // counter on flops 0..2 from feedback terms: q0'=~q0, q1'=q1^q0, q2'=q2^(q1&q0)
    ten(0,0); lit(0,0,8,0,1);
    ten(1,0); lit(1,0,9,1,0); lit(1,0,8,0,1);
    ten(1,1); lit(1,1,9,0,1); lit(1,1,8,1,0);
    ten(2,0); lit(2,0,10,1,0); lit(2,0,9,0,1);
    ten(2,1); lit(2,1,10,1,0); lit(2,1,8,0,1);
    ten(2,2); lit(2,2,10,0,1); lit(2,2,9,1,0); lit(2,2,8,1,0);
    ten(3,0); lit(3,0,3,1,0);
    // comb4 = in0&in1&~in2 | in7 ; comb5 no terms ; comb6 empty term ; comb7 conflicting terms
    ten(4,0); lit(4,0,0,1,0); lit(4,0,1,1,0); lit(4,0,2,0,1);
    ten(4,1); lit(4,1,7,1,0);
    ten(6,0);
    ten(7,0); lit(7,0,0,1,1);
    ten(7,1); lit(7,1,5,1,1);

    #1 rst_ni = 1'b0;
    @(posedge clk_i); #1;
    chk(reg_q_o == 4'h0, "R9 reset clear", reg_q_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // counter run with pins enabled
    for (int i = 0; i < 20; i++) begin
      @(posedge clk_i); #1;
      chk(reg_q_o[2:0] == 3'(exp_cnt), "R6 R7 feedback count", reg_q_o[2:0], exp_cnt);
      chk(reg_q_o[3] == exp_r3, "R6 capture in3", reg_q_o[3], exp_r3);
      in_i = 8'($urandom);
    end

    // exhaustive combinational sweep
    for (int v = 0; v < 256; v++) begin
      @(posedge clk_i); #1;
      in_i = 8'(v);
      #1;
      chk(comb_o[0] == ((in_i[0] & in_i[1] & ~in_i[2]) | in_i[7]), "R1 R4 R5 comb4", comb_o[0], 0);
      chk(comb_o[1] == 1'b0, "R3 no enabled term", comb_o[1], 0);
      chk(comb_o[2] == 1'b1, "R3 empty term is one", comb_o[2], 1);
      chk(comb_o[3] == 1'b0, "R2 true+comp forces zero", comb_o[3], 0);
    end

    // pins floated while counter keeps running
    reg_oe_i = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk_i); #1;
      chk(reg_oe_o == 1'b0, "R8 enable flag low", reg_oe_o, 0);
    end
    reg_oe_i = 1'b1;
    #1;
    chk(reg_oe_o == 1'b1, "R8 enable flag high", reg_oe_o, 1);
    chk(reg_q_o[2:0] == 3'(exp_cnt), "R7 R8 count advanced while floating", reg_q_o[2:0], exp_cnt);

    // random configurations: comb before edge, flops after edge
    for (int t = 0; t < 50; t++) begin
      @(posedge clk_i); #1;
      for (int b = 0; b < 64; b++) begin
        cfg_i[b*TW + 24] = ($urandom_range(0, 2) != 0);
        for (int k = 0; k < 12; k++) begin
          int r;
          r = $urandom_range(0, 19);
          cfg_i[b*TW + 2*k]     = (r < 3) || (r == 19);
          cfg_i[b*TW + 2*k + 1] = (r >= 3 && r < 6) || (r == 19);
        end
      end
      for (int i = 0; i < 16; i++) begin
        in_i = 8'($urandom);
        #1;
        q = reg_q_o;
        for (int j = 0; j < 4; j++)
          chk(comb_o[j] == model(4+j, in_i, q), "R1 R2 R3 R4 R5 random comb", comb_o, {28'd0, q});
        for (int j = 0; j < 4; j++) nxt[j] = model(j, in_i, q);
        @(posedge clk_i); #1;
        chk(reg_q_o == nxt, "R6 R7 random capture", reg_q_o, nxt);
      end
    end

    // async reset without a clock edge
    @(negedge clk_i); #0.5;
    rst_ni = 1'b0;
    #0.5;
    chk(reg_q_o == 4'h0, "R9 async clear", reg_q_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule